// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Region Detector

This block turns three phase reference samples into multilevel switching decisions. An external generator supplies the samples as signed values, 120 degrees apart, with the third-harmonic component already added. The block adds a stepped DC offset to each sample. The offset is chosen by a speed-range index, so that a small reference sits low in the carrier stack and a large one spreads across it. The block then compares each biased sample against eleven stacked triangular carriers. For every phase it reports, on each clock, which of twelve regions the sample falls in. Gate drive logic downstream maps each region to a voltage level.

All eleven carriers come from one triangle counter, so they stay in phase. The counter is controlled by a two-state machine with the states `TRI_RISE` and `TRI_FALL`.
- The transition `TRI_RISE -> TRI_FALL` is taken on the step that brings the counter to its peak of `CAR_H`.
- The transition `TRI_FALL -> TRI_RISE` is taken on the step that brings it back to 0.
- The sync pulse forces `TRI_RISE` with the counter at 0. This lets the controller align the carrier with the start of a reference cycle.

A carrier period lasts `2*CAR_H*(car_div+1)` clocks. The controller picks `car_div` so that this period is one forty-eighth of the reference period.

Top module: `mc_lvl_pwm`

## Requirements
- R1: Each region output equals 1 plus the number of carriers k (k = 0..10) for which `tri + k*CAR_H` is less than or equal to that phase's biased reference. A reference equal to a carrier counts as above that carrier. The output lies in 1..12.
- R2: After reset the triangle starts at 0 in `TRI_RISE`. It changes by exactly one count every `car_div+1` clocks. It reverses direction at `CAR_H` and at 0, and it never leaves the range 0..`CAR_H`.
- R3: A sync pulse puts the triangle at 0 in `TRI_RISE` on the next clock and restarts the step prescaler. The comparison made in the same cycle as the pulse still uses the old triangle value.
- R4: The bias added to every reference is `x*CAR_H/2`, where x is the 4-bit range index. An index of 0 is treated as 1, and an index above 11 is treated as 11.
- R5: The biased reference is clamped to the range 0..`11*CAR_H` before the comparison.
- R6: All three phases are compared against the same carrier values in the same cycle. Equal references in the same cycle give equal regions.
- R7: The region outputs are registered, with one clock of latency from inputs to outputs. Reset sets all three outputs to 1.
- R8: With range index 1 and every reference strictly inside ±`CAR_H/2`, only regions 1 and 2 appear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_a | input | REF_W | Phase A reference, signed |
| ref_b | input | REF_W | Phase B reference, signed |
| ref_c | input | REF_W | Phase C reference, signed |
| range_idx | input | IDX_W | Speed-range index that selects the bias |
| car_div | input | DIV_W | Clocks per triangle step, minus one |
| sync | input | 1 | Restarts the triangle at its valley |
| region_a | output | 4 | Phase A region, 1..12 |
| region_b | output | 4 | Phase B region, 1..12 |
| region_c | output | 4 | Phase C region, 1..12 |

## Verification
The hardest case to reach from the ports is a biased reference that exactly equals one of the carriers, because the triangle is never visible outside the block. The bench runs its own model of the triangle in lockstep with the design, including sync pulses that arrive mid-slope. It then builds references as `k*CAR_H + tri - bias` for the cycle being driven, so that ties land on chosen carriers in several ranges. Clamping at both ends is reached with large positive references at index 11 and large negative references at index 1.

// File: rtl/mc_lvl_pkg.sv
package mc_lvl_pkg;
    localparam int NCAR  = 11;
    localparam int NREG  = NCAR + 1;
    localparam int REG_W = 4;
    localparam int NPH   = 3;

    typedef enum logic [0:0] {
        TRI_RISE = 1'b0,
        TRI_FALL = 1'b1
    } tri_dir_e;

    typedef logic [REG_W-1:0] region_t;
endpackage

// File: rtl/mc_tri_gen.sv
module mc_tri_gen
    import mc_lvl_pkg::*;
#(
    parameter int CAR_H = 64,
    parameter int DIV_W = 8,
    parameter int TRI_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic [DIV_W-1:0] car_div,
    output logic [TRI_W-1:0] tri_val,
    output tri_dir_e         tri_dir
);
    tri_dir_e         state_q, state_d;
    logic [TRI_W-1:0] tri_q, tri_d;
    logic [DIV_W-1:0] pre_q, pre_d;
    logic             step;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRI_RISE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        step    = (pre_q >= car_div);
        state_d = state_q;
        if (sync) begin
            state_d = TRI_RISE;
        end else if (step) begin
            unique case (state_q)
                TRI_RISE: if (tri_q == TRI_W'(CAR_H - 1)) state_d = TRI_FALL;
                TRI_FALL: if (tri_q == TRI_W'(1))         state_d = TRI_RISE;
            endcase
        end
    end

    // outputs: counter and prescaler
    always_comb begin
        tri_d = tri_q;
        pre_d = step ? '0 : pre_q + 1'b1;
        if (sync) begin
            tri_d = '0;
            pre_d = '0;
        end else if (step) begin
            unique case (state_q)
                TRI_RISE: tri_d = tri_q + 1'b1;
                TRI_FALL: tri_d = tri_q - 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tri_q <= '0;
            pre_q <= '0;
        end else begin
            tri_q <= tri_d;
            pre_q <= pre_d;
        end
    end

    assign tri_val = tri_q;
    assign tri_dir = state_q;
endmodule

// File: rtl/mc_ref_bias.sv
module mc_ref_bias
    import mc_lvl_pkg::*;
#(
    parameter int CAR_H = 64,
    parameter int REF_W = 12,
    parameter int IDX_W = 4,
    parameter int BW    = 14
) (
    input  logic signed [REF_W-1:0] ref_in,
    input  logic        [IDX_W-1:0] range_idx,
    output logic signed [BW-1:0]    biased
);
    localparam int TOP = NCAR * CAR_H;

    logic        [IDX_W-1:0] idx_sat;
    logic signed [BW-1:0]    ref_ext, bias_v, sum;

    always_comb begin
        if (range_idx == '0)                 idx_sat = IDX_W'(1);
        else if (range_idx > IDX_W'(NCAR))   idx_sat = IDX_W'(NCAR);
        else                                 idx_sat = range_idx;
    end

    assign ref_ext = BW'(ref_in);
    assign bias_v  = $signed(BW'(idx_sat) * BW'(CAR_H / 2));
    assign sum     = ref_ext + bias_v;

    always_comb begin
        if (sum < 0)              biased = '0;
        else if (sum > BW'(TOP))  biased = BW'(TOP);
        else                      biased = sum;
    end
endmodule

// File: rtl/mc_region_cmp.sv
module mc_region_cmp
    import mc_lvl_pkg::*;
#(
    parameter int CAR_H = 64,
    parameter int TRI_W = 7,
    parameter int BW    = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TRI_W-1:0]     tri_val,
    input  logic signed [BW-1:0] biased,
    output region_t              region
);
    logic signed [BW-1:0] car [NCAR];
    logic [NCAR-1:0]      hit;
    region_t              cnt, region_q;

    for (genvar k = 0; k < NCAR; k++) begin : g_car
        assign car[k] = $signed(BW'(tri_val)) + BW'(k * CAR_H);
        assign hit[k] = (car[k] <= biased);
    end

    always_comb begin
        cnt = REG_W'(1);
        for (int k = 0; k < NCAR; k++) cnt = cnt + REG_W'(hit[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) region_q <= REG_W'(1);
        else        region_q <= cnt;
    end

    assign region = region_q;
endmodule

// File: rtl/mc_lvl_pwm.sv
module mc_lvl_pwm
    import mc_lvl_pkg::*;
#(
    parameter int CAR_H = 64,
    parameter int REF_W = 12,
    parameter int DIV_W = 8,
    parameter int IDX_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    input  logic signed [REF_W-1:0] ref_c,
    input  logic        [IDX_W-1:0] range_idx,
    input  logic        [DIV_W-1:0] car_div,
    input  logic                    sync,
    output logic [3:0]              region_a,
    output logic [3:0]              region_b,
    output logic [3:0]              region_c
);
    localparam int TRI_W = $clog2(CAR_H + 1);
    localparam int TOP_W = $clog2(NCAR * CAR_H + 1) + 1;
    localparam int BW    = ((REF_W > TOP_W) ? REF_W : TOP_W) + 2;

    logic [TRI_W-1:0]        tri_val;
    tri_dir_e                tri_dir;
    logic signed [REF_W-1:0] ref_arr [NPH];
    logic signed [BW-1:0]    biased  [NPH];
    region_t                 reg_arr [NPH];

    assign ref_arr[0] = ref_a;
    assign ref_arr[1] = ref_b;
    assign ref_arr[2] = ref_c;

    mc_tri_gen #(.CAR_H(CAR_H), .DIV_W(DIV_W), .TRI_W(TRI_W)) u_tri (
        .clk(clk), .rst_n(rst_n), .sync(sync), .car_div(car_div),
        .tri_val(tri_val), .tri_dir(tri_dir)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        mc_ref_bias #(.CAR_H(CAR_H), .REF_W(REF_W), .IDX_W(IDX_W), .BW(BW)) u_bias (
            .ref_in(ref_arr[p]), .range_idx(range_idx), .biased(biased[p])
        );
        mc_region_cmp #(.CAR_H(CAR_H), .TRI_W(TRI_W), .BW(BW)) u_cmp (
            .clk(clk), .rst_n(rst_n), .tri_val(tri_val),
            .biased(biased[p]), .region(reg_arr[p])
        );
    end

    assign region_a = reg_arr[0];
    assign region_b = reg_arr[1];
    assign region_c = reg_arr[2];
endmodule

// File: rtl/mc_lvl_pwm_chk.sv
module mc_lvl_pwm_chk
    import mc_lvl_pkg::*;
#(
    parameter int CAR_H = 64,
    parameter int REF_W = 12,
    parameter int IDX_W = 4,
    parameter int TRI_W = 7,
    parameter int BW    = 14
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sync,
    input logic [TRI_W-1:0]        tri_val,
    input logic [IDX_W-1:0]        range_idx,
    input logic signed [REF_W-1:0] ref_a,
    input logic signed [REF_W-1:0] ref_b,
    input logic signed [REF_W-1:0] ref_c,
    input logic signed [BW-1:0]    biased_a,
    input logic [3:0]              region_a,
    input logic [3:0]              region_b,
    input logic [3:0]              region_c
);
    localparam int HALF = CAR_H / 2;

    p_region_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (region_a >= 4'd1 && region_a <= 4'(NREG) && region_b >= 4'd1 &&
         region_b <= 4'(NREG) && region_c >= 4'd1 && region_c <= 4'(NREG)));

    p_tri_bounds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tri_val <= TRI_W'(CAR_H));

    p_tri_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> (tri_val == $past(tri_val) || tri_val == $past(tri_val) + 1'b1 ||
                   tri_val + 1'b1 == $past(tri_val)));

    p_sync_valley_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> tri_val == '0);

    p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (biased_a >= 0 && biased_a <= BW'(NCAR * CAR_H)));

    p_lockstep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_a == ref_b && ref_b == ref_c) |=> (region_a == region_b && region_b == region_c));

    p_two_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (range_idx == IDX_W'(1) &&
         ref_a > -REF_W'(HALF) && ref_a < REF_W'(HALF) &&
         ref_b > -REF_W'(HALF) && ref_b < REF_W'(HALF) &&
         ref_c > -REF_W'(HALF) && ref_c < REF_W'(HALF))
        |=> (region_a <= 4'd2 && region_b <= 4'd2 && region_c <= 4'd2));
endmodule

bind mc_lvl_pwm mc_lvl_pwm_chk #(
    .CAR_H(CAR_H), .REF_W(REF_W), .IDX_W(IDX_W), .TRI_W(TRI_W), .BW(BW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sync(sync), .tri_val(tri_val),
    .range_idx(range_idx), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .biased_a(biased[0]), .region_a(region_a), .region_b(region_b),
    .region_c(region_c)
);

// File: tb/sim_mc_lvl_pwm.sv
module sim_mc_lvl_pwm;
    localparam int EC = 64;
    localparam int RW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [RW-1:0] ref_a = '0, ref_b = '0, ref_c = '0;
    logic [3:0] range_idx = 4'd1;
    logic [7:0] car_div = '0;
    logic sync = 1'b0;
    logic [3:0] region_a, region_b, region_c;

    always #2 clk = ~clk;

    mc_lvl_pwm #(.CAR_H(EC), .REF_W(RW), .DIV_W(8), .IDX_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
        .range_idx(range_idx), .car_div(car_div), .sync(sync),
        .region_a(region_a), .region_b(region_b), .region_c(region_c)
    );

    typedef struct { int a; int b; int c; string tag; } item_t;
    item_t sb_q [$];
    int n_vec = 0, n_bad = 0;
    int m_tri = 0, m_pre = 0;
    bit m_rise = 1'b1;
    bit done = 1'b0;

    function automatic int exp_region(int r, int x);
        int xs, b, cnt;
        xs = (x < 1) ? 1 : ((x > 11) ? 11 : x);
        b = r + xs * EC / 2;
        if (b < 0) b = 0;
        if (b > 11 * EC) b = 11 * EC;
        cnt = 1;
        for (int k = 0; k < 11; k++) if (m_tri + k * EC <= b) cnt++;
        return cnt;
    endfunction

    // driver: called at a falling edge, returns at the next one
    task automatic drive(int ra, int rb, int rc, int x, int dv, bit sy, string tag);
        item_t it;
        ref_a = RW'(ra); ref_b = RW'(rb); ref_c = RW'(rc);
        range_idx = 4'(x); car_div = 8'(dv); sync = sy;
        it.a = exp_region(ra, x); it.b = exp_region(rb, x); it.c = exp_region(rc, x);
        it.tag = tag;
        sb_q.push_back(it);
        if (sy) begin
            m_tri = 0; m_rise = 1'b1; m_pre = 0;
        end else if (m_pre >= dv) begin
            m_pre = 0;
            if (m_rise) begin m_tri++; if (m_tri == EC) m_rise = 1'b0; end
            else begin m_tri--; if (m_tri == 0) m_rise = 1'b1; end
        end else begin
            m_pre++;
        end
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk); #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_vec++;
                if (region_a != 4'(it.a) || region_b != 4'(it.b) || region_c != 4'(it.c)) begin
                    n_bad++;
                    $display("FAIL %s: got %0d/%0d/%0d expected %0d/%0d/%0d", it.tag,
                             region_a, region_b, region_c, it.a, it.b, it.c);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int r;
        repeat (3) @(negedge clk);
        // R7 reset value
        n_vec++;
        if (region_a != 4'd1 || region_b != 4'd1 || region_c != 4'd1) begin
            n_bad++;
            $display("FAIL R7: got %0d/%0d/%0d expected 1/1/1", region_a, region_b, region_c);
        end
        rst_n = 1'b1;
        // R2 constant reference traces triangle shape, R8 small amplitude
        for (int i = 0; i < 300; i++) drive(0, 5, -5, 1, 2, 1'b0, "R2");
        for (int i = 0; i < 400; i++)
            drive($urandom_range(0, 62) - 31, $urandom_range(0, 62) - 31,
                  $urandom_range(0, 62) - 31, 1, 0, 1'b0, "R8");
        // R4 every index including saturating ones
        for (int x = 0; x < 16; x++)
            for (int i = 0; i < 80; i++)
                drive($urandom_range(0, 400) - 200, $urandom_range(0, 400) - 200,
                      $urandom_range(0, 400) - 200, x, 1, 1'b0, "R4");
        // R5 clamp high and low
        for (int i = 0; i < 150; i++) drive(1500, 2000, 800, 11, 0, 1'b0, "R5");
        for (int i = 0; i < 150; i++) drive(-2000, -1000, -300, 1, 0, 1'b0, "R5");
        // R1 exact ties with carriers
        for (int x = 2; x <= 11; x += 3)
            for (int i = 0; i < 200; i++) begin
                int k;
                k = $urandom_range(0, 10);
                r = k * EC + m_tri - x * EC / 2;
                drive(r, r + 1, r - 1, x, 0, 1'b0, "R1");
            end
        // R3 sync mid-slope
        for (int i = 0; i < 1500; i++)
            drive($urandom_range(0, 600) - 300, $urandom_range(0, 600) - 300,
                  $urandom_range(0, 600) - 300, 6, 3, ($urandom_range(0, 60) == 0), "R3");
        // R6 identical references
        for (int i = 0; i < 300; i++) begin
            r = $urandom_range(0, 700) - 350;
            drive(r, r, r, 7, 0, 1'b0, "R6");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule